// File: doc/BRIEF.md
# Three-Stage Instruction Pipeline Flow Controller

This block sequences instruction words through fetch, decode and execute and decides, every clock, whether each stage advances, holds or is emptied. It owns the program counter, places it on a same-cycle instruction memory read port, and keeps a valid bit, the instruction word and its address for the decode and execute stages. It knows nothing of what an instruction means. The surrounding datapath tells it, for the instruction now in execute, how many execute cycles it needs, whether it is a taken branch, and where that branch goes.

An instruction that needs more than one execute cycle holds fetch and decode in place until its last execute cycle. Branches resolve only on the last execute cycle of the branch. A taken branch loads its target into the program counter and, by default, empties the two younger stages, which costs two cycles. A compile-time delay-slot count of 1 or 2 keeps that many instructions after the branch, and they execute on both paths. A retire strobe marks the last execute cycle of every instruction that completes.

Top module: `pipe3_flow_ctrl`

## Requirements
- R1: A synchronous active-high reset makes the fetch address 0, clears both stage valid bits and holds retire low.
- R2: When the front is not held and no redirect occurs, the fetch address grows by PC_STEP (default 4) on the next clock.
- R3: An instruction fetched in cycle t with a one-cycle execute retires in cycle t+2, and back-to-back one-cycle instructions retire on consecutive clocks.
- R4: An instruction whose execute count is N stays in execute for N consecutive clocks and pulses retire only in the last of them.
- R5: While the execute instruction is not in its last cycle, the stall output is high and the fetch address, the decode stage and the execute stage keep their values.
- R6: With zero delay slots, a taken branch empties decode and drops the instruction being fetched, and the fetch address on the next clock equals the branch target, so the target retires two cycles later than a fall-through instruction would.
- R7: A branch that is not taken causes no redirect and adds no cycle.
- R8: The branch-taken input has effect only on the last execute cycle of a valid instruction; on earlier cycles of a multi-cycle branch it causes no redirect.
- R9: With DELAY_SLOTS = 1 the instruction right after a taken branch still executes and retires, the one after it is dropped, and the target retires one cycle later than a fall-through instruction would after a one-cycle slot.
- R10: Retire is only asserted while execute holds a valid instruction; dropped instructions never retire.
- R11: An execute count of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | output | ADDR_W | Program counter, the instruction memory read address |
| imem_rdata | input | INSTR_W | Instruction word at fetch_pc, same cycle |
| ex_cycles | input | CNT_W | Execute cycle count of the instruction in execute |
| br_taken | input | 1 | Instruction in execute is a taken branch |
| br_target | input | ADDR_W | Branch target address |
| de_valid | output | 1 | Decode stage holds a live instruction |
| de_instr | output | INSTR_W | Decode stage instruction word |
| de_pc | output | ADDR_W | Decode stage instruction address |
| ex_valid | output | 1 | Execute stage holds a live instruction |
| ex_instr | output | INSTR_W | Execute stage instruction word |
| ex_pc | output | ADDR_W | Execute stage instruction address |
| stall_front | output | 1 | Fetch and decode are held this cycle |
| redirect | output | 1 | Taken branch resolves this cycle |
| retire | output | 1 | Execute instruction completes this cycle |

## Verification
The properties assume that ex_cycles, br_taken and br_target are functions of the execute-stage instruction and stay steady for as long as it sits there, that the memory returns the word for fetch_pc within the same cycle, and that no branch is placed in a delay slot. The bench keeps to this by deriving all three execute inputs combinationally from ex_instr and a loop counter advanced only on retire, and its programs keep delay-slot instructions one-cycle and non-branching. Flag values seen on non-final or invalid execute cycles are still driven, so the gating of the branch flag is exercised.

// File: rtl/pipe3_pkg.sv
package pipe3_pkg;

   // Largest delay-slot count the pipeline depth can honour.
   localparam int unsigned MAX_SLOTS = 2;

   // How the program counter moves on the next clock.
   typedef enum logic [1:0] {
      PC_ADV_STEP     = 2'd0,
      PC_ADV_HOLD     = 2'd1,
      PC_ADV_REDIRECT = 2'd2
   } pc_adv_e;

   // Pick the program counter action from the pipeline control terms.
   function automatic pc_adv_e pc_action(input logic hold, input logic jump);
      if (hold)      return PC_ADV_HOLD;
      else if (jump) return PC_ADV_REDIRECT;
      else           return PC_ADV_STEP;
   endfunction

endpackage

// File: rtl/pipe3_pc_gen.sv
module pipe3_pc_gen
   import pipe3_pkg::*;
#(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned PC_STEP = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  pc_adv_e           action,
   input  logic [ADDR_W-1:0] target,
   output logic [ADDR_W-1:0] pc
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(PC_STEP);

   always_ff @(posedge clk) begin
      if (rst) begin
         pc <= '0;
      end else begin
         unique case (action)
            PC_ADV_HOLD:     pc <= pc;
            PC_ADV_REDIRECT: pc <= target;
            default:         pc <= pc + STEP;
         endcase
      end
   end

endmodule

// File: rtl/pipe3_stage_reg.sv
module pipe3_stage_reg #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              hold,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic [ADDR_W-1:0] in_pc,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic [ADDR_W-1:0] out_pc
);

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_pc    <= '0;
      end else if (!hold) begin
         out_valid <= in_valid;
         out_data  <= in_data;
         out_pc    <= in_pc;
      end
   end

endmodule

// File: rtl/pipe3_ex_timer.sv
module pipe3_ex_timer #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             active,
   input  logic [CNT_W-1:0] cycles,
   output logic             last
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] spent;

   // A count of zero or one finishes in the first execute cycle.
   always_comb begin
      last = (cycles <= ONE) || (spent == cycles - ONE);
   end

   always_ff @(posedge clk) begin
      if (rst || !active || last) spent <= '0;
      else                        spent <= spent + ONE;
   end

endmodule

// File: rtl/pipe3_flow_ctrl.sv
module pipe3_flow_ctrl
   import pipe3_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned INSTR_W     = 32,
   parameter int unsigned CNT_W       = 4,
   parameter int unsigned PC_STEP     = 4,
   parameter int unsigned DELAY_SLOTS = 0
) (
   input  logic               clk,
   input  logic               rst,
   output logic [ADDR_W-1:0]  fetch_pc,
   input  logic [INSTR_W-1:0] imem_rdata,
   input  logic [CNT_W-1:0]   ex_cycles,
   input  logic               br_taken,
   input  logic [ADDR_W-1:0]  br_target,
   output logic               de_valid,
   output logic [INSTR_W-1:0] de_instr,
   output logic [ADDR_W-1:0]  de_pc,
   output logic               ex_valid,
   output logic [INSTR_W-1:0] ex_instr,
   output logic [ADDR_W-1:0]  ex_pc,
   output logic               stall_front,
   output logic               redirect,
   output logic               retire
);

   // Elaboration-time parameter checks.
   if (DELAY_SLOTS > MAX_SLOTS) begin : g_bad_slots
      $error("DELAY_SLOTS exceeds the number of younger stages");
   end
   if (PC_STEP == 0) begin : g_bad_step
      $error("PC_STEP must be non-zero");
   end
   if (CNT_W < 1 || ADDR_W < 2 || INSTR_W < 1) begin : g_bad_width
      $error("widths too small");
   end

   logic    ex_last;
   logic    kill_into_de;
   logic    kill_into_ex;
   pc_adv_e pc_act;

   always_comb begin
      stall_front = ex_valid && !ex_last;
      retire      = ex_valid && ex_last;
      redirect    = retire && br_taken;
      pc_act      = pc_action(stall_front, redirect);
   end

   // Which younger instructions a taken branch throws away.
   if (DELAY_SLOTS == 0) begin : g_slots0
      assign kill_into_ex = redirect;
      assign kill_into_de = redirect;
   end else if (DELAY_SLOTS == 1) begin : g_slots1
      assign kill_into_ex = 1'b0;
      assign kill_into_de = redirect;
   end else begin : g_slots2
      assign kill_into_ex = 1'b0;
      assign kill_into_de = 1'b0;
   end

   pipe3_pc_gen #(
      .ADDR_W  (ADDR_W),
      .PC_STEP (PC_STEP)
   ) u_pc (
      .clk    (clk),
      .rst    (rst),
      .action (pc_act),
      .target (br_target),
      .pc     (fetch_pc)
   );

   pipe3_stage_reg #(
      .DATA_W (INSTR_W),
      .ADDR_W (ADDR_W)
   ) u_de (
      .clk       (clk),
      .rst       (rst),
      .hold      (stall_front),
      .in_valid  (!kill_into_de),
      .in_data   (imem_rdata),
      .in_pc     (fetch_pc),
      .out_valid (de_valid),
      .out_data  (de_instr),
      .out_pc    (de_pc)
   );

   pipe3_stage_reg #(
      .DATA_W (INSTR_W),
      .ADDR_W (ADDR_W)
   ) u_ex (
      .clk       (clk),
      .rst       (rst),
      .hold      (stall_front),
      .in_valid  (de_valid && !kill_into_ex),
      .in_data   (de_instr),
      .in_pc     (de_pc),
      .out_valid (ex_valid),
      .out_data  (ex_instr),
      .out_pc    (ex_pc)
   );

   pipe3_ex_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk    (clk),
      .rst    (rst),
      .active (ex_valid),
      .cycles (ex_cycles),
      .last   (ex_last)
   );

endmodule

// File: rtl/pipe3_flow_ctrl_chk.sv
module pipe3_flow_ctrl_chk #(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned PC_STEP     = 4,
   parameter int unsigned DELAY_SLOTS = 0
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] fetch_pc,
   input logic              br_taken,
   input logic [ADDR_W-1:0] br_target,
   input logic              de_valid,
   input logic [ADDR_W-1:0] de_pc,
   input logic              ex_valid,
   input logic [ADDR_W-1:0] ex_pc,
   input logic              stall_front,
   input logic              redirect,
   input logic              retire
);

   p_reset_state_r1: assert property (@(posedge clk)
      rst |=> (fetch_pc == '0 && !de_valid && !ex_valid && !retire));

   p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
      (!stall_front && !redirect) |=> fetch_pc == $past(fetch_pc) + ADDR_W'(PC_STEP));

   p_advance_r3: assert property (@(posedge clk) disable iff (rst)
      (de_valid && !stall_front && !redirect) |=> (ex_valid && ex_pc == $past(de_pc)));

   p_stall_busy_r4: assert property (@(posedge clk) disable iff (rst)
      stall_front |-> (ex_valid && !retire));

   p_hold_front_r5: assert property (@(posedge clk) disable iff (rst)
      stall_front |=> ($stable(fetch_pc) && $stable(de_pc) && $stable(de_valid) && $stable(ex_pc)));

   p_redirect_pc_r6: assert property (@(posedge clk) disable iff (rst)
      redirect |=> fetch_pc == $past(br_target));

   p_branch_gate_r8: assert property (@(posedge clk) disable iff (rst)
      redirect |-> (br_taken && retire && ex_valid));

   p_retire_valid_r10: assert property (@(posedge clk) disable iff (rst)
      retire |-> ex_valid);

   if (DELAY_SLOTS == 0) begin : g_flush
      p_flush_both_r6: assert property (@(posedge clk) disable iff (rst)
         redirect |=> (!ex_valid && !de_valid));
   end else if (DELAY_SLOTS == 1) begin : g_slot1
      p_slot_kept_r9: assert property (@(posedge clk) disable iff (rst)
         redirect |=> (ex_valid == $past(de_valid) && !de_valid));
   end else begin : g_slot2
      p_slots_kept_r9: assert property (@(posedge clk) disable iff (rst)
         redirect |=> (ex_valid == $past(de_valid) && de_valid));
   end

endmodule

bind pipe3_flow_ctrl pipe3_flow_ctrl_chk #(
   .ADDR_W      (ADDR_W),
   .PC_STEP     (PC_STEP),
   .DELAY_SLOTS (DELAY_SLOTS)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .fetch_pc    (fetch_pc),
   .br_taken    (br_taken),
   .br_target   (br_target),
   .de_valid    (de_valid),
   .de_pc       (de_pc),
   .ex_valid    (ex_valid),
   .ex_pc       (ex_pc),
   .stall_front (stall_front),
   .redirect    (redirect),
   .retire      (retire)
);

// File: tb/tb_pipe3_flow_ctrl.sv
`timescale 1ns/1ps
module tb_pipe3_flow_ctrl;

   localparam int LOOPS = 2;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   int cyc;
   bit armed = 1'b0;
   string cur_req = "R3";

   logic [31:0] prog [0:31];
   logic [63:0] q0 [$];
   logic [63:0] q1 [$];

   // Bench encoding: [3:0] execute count, [4] branch, [5] always taken
   // (else loop branch, taken while its count is below LOOPS), [31:16] target word.
   function automatic logic [31:0] mk(input int c, input bit br, input bit alw, input int tgt);
      return {16'(tgt), 10'd0, alw, br, 4'(c)};
   endfunction

   function automatic logic [31:0] wd(input logic [31:0] a);
      if (a < 32'd128) return prog[a[6:2]];
      return 32'h1;
   endfunction

   // Instance with zero delay slots.
   logic [31:0] pc0, de_i0, ex_i0, de_p0, ex_p0;
   logic de_v0, ex_v0, st0, rd0, rt0, tk0;
   int lc0;
   assign tk0 = ex_i0[4] && (ex_i0[5] || lc0 < LOOPS);

   pipe3_flow_ctrl #(.DELAY_SLOTS(0)) dut (
      .clk(clk), .rst(rst), .fetch_pc(pc0), .imem_rdata(wd(pc0)),
      .ex_cycles(ex_i0[3:0]), .br_taken(tk0), .br_target({14'd0, ex_i0[31:16], 2'b00}),
      .de_valid(de_v0), .de_instr(de_i0), .de_pc(de_p0),
      .ex_valid(ex_v0), .ex_instr(ex_i0), .ex_pc(ex_p0),
      .stall_front(st0), .redirect(rd0), .retire(rt0));

   // Instance with one delay slot.
   logic [31:0] pc1, de_i1, ex_i1, de_p1, ex_p1;
   logic de_v1, ex_v1, st1, rd1, rt1, tk1;
   int lc1;
   assign tk1 = ex_i1[4] && (ex_i1[5] || lc1 < LOOPS);

   pipe3_flow_ctrl #(.DELAY_SLOTS(1)) dut_slot (
      .clk(clk), .rst(rst), .fetch_pc(pc1), .imem_rdata(wd(pc1)),
      .ex_cycles(ex_i1[3:0]), .br_taken(tk1), .br_target({14'd0, ex_i1[31:16], 2'b00}),
      .de_valid(de_v1), .de_instr(de_i1), .de_pc(de_p1),
      .ex_valid(ex_v1), .ex_instr(ex_i1), .ex_pc(ex_p1),
      .stall_front(st1), .redirect(rd1), .retire(rt1));

   always_ff @(posedge clk) begin
      if (rst) begin
         cyc <= 0; lc0 <= 0; lc1 <= 0;
      end else begin
         cyc <= cyc + 1;
         if (rt0 && ex_i0[4] && !ex_i0[5]) lc0 <= lc0 + 1;
         if (rt1 && ex_i1[4] && !ex_i1[5]) lc1 <= lc1 + 1;
      end
   end

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Driver: reference model of the retire order and cycle of each instruction.
   task automatic ref_push(input int d, input int n);
      int t = 1;
      logic [31:0] pc = 0;
      int lc = 0;
      bit jmp = 0;
      int slots = 0;
      logic [31:0] tgt = 0;
      for (int k = 0; k < n; k++) begin
         logic [31:0] w;
         logic [31:0] npc;
         int c;
         w = wd(pc);
         c = (w[3:0] == 0) ? 1 : int'(w[3:0]);
         if (jmp) begin t += 2 - d; jmp = 0; end
         t += c;
         if (d == 0) q0.push_back({pc, 32'(t)});
         else        q1.push_back({pc, 32'(t)});
         npc = pc + 4;
         if (slots > 0) begin
            slots--;
            if (slots == 0) begin npc = tgt; jmp = 1; end
         end else if (w[4] && (w[5] || lc < LOOPS)) begin
            tgt = {14'd0, w[31:16], 2'b00};
            if (d == 0) begin npc = tgt; jmp = 1; end
            else slots = d;
         end
         if (w[4] && !w[5]) lc++;
         pc = npc;
      end
   endtask

   // Monitor: scoreboard comparison of retires, plus front-end movement checks.
   logic [31:0] p_pc, p_tgt;
   bit p_st, p_rd, p_ok;
   always @(negedge clk) begin
      if (rst) begin
         p_ok = 1'b0;
      end else begin
         if (armed && rt0 && q0.size() > 0) begin
            logic [63:0] e0;
            e0 = q0.pop_front();
            chk(cur_req, "retire pc", ex_p0, e0[63:32]);
            chk(cur_req, "retire cycle", 32'(cyc), e0[31:0]);
         end
         if (armed && rt1 && q1.size() > 0) begin
            logic [63:0] e1;
            e1 = q1.pop_front();
            chk("R9", "slot retire pc", ex_p1, e1[63:32]);
            chk("R9", "slot retire cycle", 32'(cyc), e1[31:0]);
         end
         if (p_ok) begin
            if (p_st)      chk("R5", "held pc", pc0, p_pc);
            else if (p_rd) chk("R6", "redirect pc", pc0, p_tgt);
            else           chk("R2", "stepped pc", pc0, p_pc + 32'd4);
         end
         p_pc  = pc0;
         p_st  = st0;
         p_rd  = rd0;
         p_tgt = {14'd0, ex_i0[31:16], 2'b00};
         p_ok  = 1'b1;
      end
   end

   task automatic run(input string req, input int n);
      int waited = 0;
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", "reset pc", pc0, 32'd0);
      chk("R1", "reset valids", {30'd0, de_v0, ex_v0}, 32'd0);
      chk("R1", "reset retire", {31'd0, rt0}, 32'd0);
      q0.delete(); q1.delete();
      ref_push(0, n);
      ref_push(1, n);
      cur_req = req;
      armed = 1'b1;
      rst = 1'b0;
      while ((q0.size() > 0 || q1.size() > 0) && waited < 300) begin
         @(negedge clk);
         waited++;
      end
      #1;
      if (q0.size() > 0 || q1.size() > 0) begin
         checks++; errors++;
         $display("FAIL %s run timeout actual %0d expected %0d", req, q0.size() + q1.size(), 0);
      end
      armed = 1'b0;
   endtask

   initial begin
      // Straight-line code: one retire per clock, first at cycle 2.
      for (int i = 0; i < 32; i++) prog[i] = mk(1, 0, 0, 0);
      run("R3", 8);

      // Multi-cycle execute, including a zero count (R4 R11).
      prog[1] = mk(2, 0, 0, 0);
      prog[3] = mk(0, 0, 0, 0);
      prog[4] = mk(3, 0, 0, 0);
      run("R4 R11", 7);

      // Loop: taken back-branch twice, then not taken (R6 R7 R10).
      for (int i = 0; i < 32; i++) prog[i] = mk(1, 0, 0, 0);
      prog[2] = mk(1, 1, 0, 1);
      run("R6 R7 R10", 12);

      // Two-cycle always-taken branch: flag high on its first cycle too (R8).
      for (int i = 0; i < 32; i++) prog[i] = mk(1, 0, 0, 0);
      prog[1] = mk(2, 1, 1, 8);
      prog[8] = mk(2, 0, 0, 0);
      run("R8", 6);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #500000;
      checks++; errors++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule